// File: doc/BRIEF.md
# MDIO Management Frame Slave Decoder

This block sits on the PHY side of a two-wire management bus. It follows the serial clock (MDC) and the bidirectional data line (MDIO) and decodes clause-22 style management frames. A frame is a preamble, a start pair, a two-bit opcode, a five-bit PHY address, a five-bit register index, a two-bit turnaround and sixteen data bits. For a read addressed to this slave, the block fetches one word from an attached register file and shifts it out. For a write addressed to this slave, it collects the sixteen data bits and then hands the complete word to the register file in a single strobe.

MDC runs much slower than the system clock, and both bus lines are asynchronous to it. Each line passes through a two-flop synchroniser, and MDC edges are found by comparing successive synchronised samples. The output stage is tristate-style: a data bit and an output-enable, which the pad logic combines. The attached register file must answer combinationally: `reg_rdata` must be valid in the same cycle that `reg_rd_en` is high, for the index on `reg_addr`.

Top module: `mdio_slave_decoder`

## Requirements
- R1: After reset, `mdio_oe`, `mdio_out`, `reg_rd_en`, `reg_wr_en` and `start_err` are all 0.
- R2: A frame starts only when MDIO is 0 at an MDC rising edge preceded by at least PRE_MIN (default 32) rising edges since the last frame or reset. A 0 seen earlier starts nothing, and the data that follows causes no register write.
- R3: The start state lasts one MDC period. If MDIO is not 1 at its rising edge, `start_err` pulses high for one system clock and decoding continues normally.
- R4: The opcode (2 bits), then the PHY address (5 bits), then the register index (5 bits) are shifted in MSB first on MDC rising edges. The register index appears on `reg_addr`.
- R5: For opcode 2'b10 (read) to address PHY_ADDR (default 1), `reg_rd_en` pulses once at the second turnaround rising edge. `mdio_oe` goes high from the next system clock through the 16th data rising edge. The word is driven MSB first, with each bit changing on an MDC falling edge.
- R6: A read to any other PHY address drives 16'hFFFF with `mdio_oe` high and raises no `reg_rd_en`.
- R7: For opcode 2'b01 (write) to PHY_ADDR, exactly one `reg_wr_en` pulse carries all 16 data bits (MSB first on the wire) on `reg_wdata`. It comes after the 16th data rising edge and never earlier.
- R8: Writes to other PHY addresses, and frames with opcode 2'b00 or 2'b11, raise no `reg_wr_en` and never assert `mdio_oe`. `mdio_oe` is high only during the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than MDC |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc_in | input | 1 | Management clock from the bus master (asynchronous) |
| mdio_in | input | 1 | Management data line as seen at the pad (asynchronous) |
| mdio_out | output | 1 | Data value to drive onto MDIO when enabled |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |
| reg_addr | output | 5 | Register index of the current or last frame |
| reg_rd_en | output | 1 | One-cycle read strobe to the register file |
| reg_rdata | input | 16 | Register file read data, valid combinationally with `reg_rd_en` |
| reg_wr_en | output | 1 | One-cycle write strobe to the register file |
| reg_wdata | output | 16 | Write data, valid with `reg_wr_en` |
| start_err | output | 1 | One-cycle pulse when the second start bit is not 1 |

## Verification
The hardest case to reach from the ports is a zero that arrives before the preamble count is satisfied. Such a frame must not be decoded at all, and no later bit of it may look like a start. The bench sends an 8-bit preamble and then a write whose trailing data bits are all ones, so that no zero falls after the 32nd edge, and then checks that no write happens and that the next correct frame still works. A second directed frame carries a bad start pair, to show that the error pulse does not break decoding. Random frames then mix opcodes, matched and unmatched PHY addresses, and data words. They are checked against a bench register model.

// File: rtl/mdio_slave_pkg.sv
// Shared types and constants for the MDIO slave decoder.
// Assumes clause-22 framing: 2-bit opcode, 5-bit fields, 16-bit data.
package mdio_slave_pkg;
    localparam int OPC_W   = 2;
    localparam int FIELD_W = 5;
    localparam int DATA_W  = 16;

    localparam logic [OPC_W-1:0] OPC_RD = 2'b10;
    localparam logic [OPC_W-1:0] OPC_WR = 2'b01;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,   // counting preamble
        PH_START = 3'd1,   // second start bit
        PH_OPC   = 3'd2,
        PH_PHY   = 3'd3,
        PH_REG   = 3'd4,
        PH_TA    = 3'd5,
        PH_DATA  = 3'd6
    } mdio_phase_e;
endpackage

// File: rtl/mdio_mdc_edges.sv
// Synchronises the asynchronous MDC input and produces one-cycle rise and
// fall strobes. Assumes MDC stays in each level for several system clocks.
module mdio_mdc_edges #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_async,
    output logic mdc_rise,
    output logic mdc_fall
);
    logic [STAGES:0] pipe;

    // Shift MDC through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], mdc_async};
    end

    // Compare the synchronised level with its previous value.
    always_comb begin
        mdc_rise = pipe[STAGES-1] & ~pipe[STAGES];
        mdc_fall = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/mdio_line_sync.sv
// Synchronises the MDIO data line with the same latency as the MDC edge
// detector, so a rise strobe lines up with the bit the master set up.
module mdio_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);
    logic [STAGES-1:0] pipe;

    // Plain multi-flop synchroniser, reset to the idle bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], line_async};
    end

    assign line_sync = pipe[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
// Frame decoder: walks preamble, start, opcode, PHY address, register index,
// turnaround and data on MDC rising edges. Produces combinational strobes at
// the end of turnaround and at the last data bit, and a registered write
// commit. Assumes mdio_bit is aligned with mdc_rise.
module mdio_frame_fsm
    import mdio_slave_pkg::*;
#(
    parameter int PHY_ADDR = 1,
    parameter int PRE_MIN  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mdc_rise,
    input  logic               mdio_bit,
    output mdio_phase_e        phase,
    output logic               start_err,
    output logic [FIELD_W-1:0] reg_addr,
    output logic               addr_hit,
    output logic               is_read,
    output logic               ta_done,
    output logic               data_last,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wdata
);
    localparam int PRE_W = $clog2(PRE_MIN + 1);
    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam logic [PRE_W-1:0]   PRE_LIM  = PRE_W'(PRE_MIN);
    localparam logic [CNT_W-1:0]   OPC_END  = CNT_W'(OPC_W - 1);
    localparam logic [CNT_W-1:0]   FLD_END  = CNT_W'(FIELD_W - 1);
    localparam logic [CNT_W-1:0]   TA_END   = CNT_W'(1);
    localparam logic [CNT_W-1:0]   DAT_END  = CNT_W'(DATA_W - 1);
    localparam logic [FIELD_W-1:0] OWN_ADDR = FIELD_W'(PHY_ADDR);

    mdio_phase_e         phase_q;
    logic [PRE_W-1:0]    pre_cnt;
    logic [CNT_W-1:0]    bit_cnt;
    logic [OPC_W-1:0]    opc_q;
    logic [FIELD_W-1:0]  phy_q;
    logic [FIELD_W-1:0]  reg_q;
    logic [DATA_W-1:0]   shift_q;
    logic                start_err_q;
    logic                wr_en_q;
    logic [DATA_W-1:0]   wdata_q;

    // Decode strobes and address match from the current field registers.
    always_comb begin
        addr_hit  = (phy_q == OWN_ADDR);
        is_read   = (opc_q == OPC_RD);
        ta_done   = mdc_rise && (phase_q == PH_TA) && (bit_cnt == TA_END);
        data_last = mdc_rise && (phase_q == PH_DATA) && (bit_cnt == DAT_END);
    end

    // Frame state machine, advanced only on MDC rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            pre_cnt     <= '0;
            bit_cnt     <= '0;
            opc_q       <= '0;
            phy_q       <= '0;
            reg_q       <= '0;
            shift_q     <= '0;
            start_err_q <= 1'b0;
            wr_en_q     <= 1'b0;
            wdata_q     <= '0;
        end else begin
            start_err_q <= 1'b0;
            wr_en_q     <= 1'b0;
            if (mdc_rise) begin
                case (phase_q)
                    PH_IDLE: begin
                        if ((pre_cnt >= PRE_LIM) && !mdio_bit) begin
                            phase_q <= PH_START;
                            bit_cnt <= '0;
                            pre_cnt <= '0;
                        end else if (pre_cnt < PRE_LIM) begin
                            pre_cnt <= pre_cnt + 1'b1;
                        end
                    end
                    PH_START: begin
                        start_err_q <= !mdio_bit;
                        phase_q     <= PH_OPC;
                        bit_cnt     <= '0;
                    end
                    PH_OPC: begin
                        opc_q <= {opc_q[OPC_W-2:0], mdio_bit};
                        if (bit_cnt == OPC_END) begin
                            phase_q <= PH_PHY;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_PHY: begin
                        phy_q <= {phy_q[FIELD_W-2:0], mdio_bit};
                        if (bit_cnt == FLD_END) begin
                            phase_q <= PH_REG;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_REG: begin
                        reg_q <= {reg_q[FIELD_W-2:0], mdio_bit};
                        if (bit_cnt == FLD_END) begin
                            phase_q <= PH_TA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_TA: begin
                        if (bit_cnt == TA_END) begin
                            phase_q <= PH_DATA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        shift_q <= {shift_q[DATA_W-2:0], mdio_bit};
                        if (bit_cnt == DAT_END) begin
                            phase_q <= PH_IDLE;
                            bit_cnt <= '0;
                            pre_cnt <= '0;
                            wdata_q <= {shift_q[DATA_W-2:0], mdio_bit};
                            wr_en_q <= (opc_q == OPC_WR) && addr_hit;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign phase     = phase_q;
    assign start_err = start_err_q;
    assign reg_addr  = reg_q;
    assign wr_en     = wr_en_q;
    assign wdata     = wdata_q;

    // R2
    pre_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_START && $past(phase_q) == PH_IDLE) |-> ($past(pre_cnt) >= PRE_LIM));

    // R3
    start_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_q |-> ($past(phase_q) == PH_START));

    // R7
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> (phase_q == PH_IDLE && $past(phase_q) == PH_DATA));
endmodule

// File: rtl/mdio_read_driver.sv
// Read-side output stage: loads the fetched word at the end of turnaround,
// drives it MSB first, changing on MDC falling edges, and releases the line
// on the last data rising edge.
module mdio_read_driver #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              fall_en,
    input  logic              drop_en,
    output logic              mdio_out,
    output logic              mdio_oe
);
    logic [DATA_W-1:0] sh_q;

    // Output shift register and pad enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else if (drop_en) begin
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else if (load_en) begin
            sh_q     <= load_val;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b1;
        end else if (fall_en && mdio_oe) begin
            mdio_out <= sh_q[DATA_W-1];
            sh_q     <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    // R5
    oe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(load_en));
endmodule

// File: rtl/mdio_slave_decoder.sv
// Top level of the MDIO slave decoder: synchronisers, frame FSM and read
// driver. Assumes an attached register file with combinational read data.
module mdio_slave_decoder
    import mdio_slave_pkg::*;
#(
    parameter int PHY_ADDR    = 1,
    parameter int PRE_MIN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mdc_in,
    input  logic               mdio_in,
    output logic               mdio_out,
    output logic               mdio_oe,
    output logic [FIELD_W-1:0] reg_addr,
    output logic               reg_rd_en,
    input  logic [DATA_W-1:0]  reg_rdata,
    output logic               reg_wr_en,
    output logic [DATA_W-1:0]  reg_wdata,
    output logic               start_err
);
    logic        mdc_rise, mdc_fall, mdio_bit;
    logic        addr_hit, is_read, ta_done, data_last, rd_strobe;
    mdio_phase_e phase;
    logic [DATA_W-1:0] rd_value;

    mdio_mdc_edges #(.STAGES(SYNC_STAGES)) u_mdc (
        .clk(clk), .rst_n(rst_n), .mdc_async(mdc_in),
        .mdc_rise(mdc_rise), .mdc_fall(mdc_fall)
    );

    mdio_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dat (
        .clk(clk), .rst_n(rst_n), .line_async(mdio_in), .line_sync(mdio_bit)
    );

    mdio_frame_fsm #(.PHY_ADDR(PHY_ADDR), .PRE_MIN(PRE_MIN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_bit(mdio_bit),
        .phase(phase), .start_err(start_err), .reg_addr(reg_addr),
        .addr_hit(addr_hit), .is_read(is_read), .ta_done(ta_done),
        .data_last(data_last), .wr_en(reg_wr_en), .wdata(reg_wdata)
    );

    // Read fetch: strobe the register file only for this slave's address.
    always_comb begin
        rd_strobe = ta_done && is_read;
        reg_rd_en = rd_strobe && addr_hit;
        rd_value  = addr_hit ? reg_rdata : {DATA_W{1'b1}};
    end

    mdio_read_driver #(.DATA_W(DATA_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .load_en(rd_strobe), .load_val(rd_value),
        .fall_en(mdc_fall), .drop_en(data_last),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    // R8
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (phase == PH_DATA && is_read));

    // R5
    rd_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> mdio_oe);
endmodule

// File: tb/mdio_slave_decoder_test.sv
`timescale 1ns/1ps
module mdio_slave_decoder_test;
    localparam int PHY  = 1;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc_in = 1'b0;
    logic        mdio_in = 1'b1;
    logic        mdio_out, mdio_oe, reg_rd_en, reg_wr_en, start_err;
    logic [4:0]  reg_addr;
    logic [15:0] reg_rdata, reg_wdata;

    logic [15:0] dev_mem [32];
    logic [15:0] exp_mem [32];
    int wr_cnt = 0, rd_cnt = 0, serr_cnt = 0;
    int checks = 0, errs = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mdio_slave_decoder #(.PHY_ADDR(PHY)) uut (
        .clk(clk), .rst_n(rst_n), .mdc_in(mdc_in), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
        .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .start_err(start_err)
    );

    // Attached register file model (combinational read).
    assign reg_rdata = dev_mem[reg_addr];
    always @(posedge clk) begin
        if (reg_wr_en) begin
            dev_mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd_en) rd_cnt <= rd_cnt + 1;
        if (start_err) serr_cnt <= serr_cnt + 1;
    end

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'h0F13) ^ 16'h5A00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, output logic smp, output logic oe_s);
        mdio_in = b;
        repeat (HALF) @(negedge clk);
        smp  = mdio_out;
        oe_s = mdio_oe;
        mdc_in = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc_in = 1'b0;
    endtask

    task automatic send_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                              input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                              output logic [15:0] rd, output logic oe_all, output logic oe_any,
                              output int wr_before_last);
        logic s, o;
        rd = '0; oe_all = 1'b1; oe_any = 1'b0; wr_before_last = 0;
        for (int k = 0; k < pre; k++) begin put_bit(1'b1, s, o); oe_any |= o; end
        for (int k = 1; k >= 0; k--) begin put_bit(st[k], s, o); oe_any |= o; end
        for (int k = 1; k >= 0; k--) begin put_bit(op[k], s, o); oe_any |= o; end
        for (int k = 4; k >= 0; k--) begin put_bit(phy[k], s, o); oe_any |= o; end
        for (int k = 4; k >= 0; k--) begin put_bit(rg[k], s, o); oe_any |= o; end
        put_bit(1'b1, s, o); oe_any |= o;
        put_bit((op == 2'b10) ? 1'b1 : 1'b0, s, o); oe_any |= o;
        for (int k = 15; k >= 0; k--) begin
            if (k == 0) wr_before_last = wr_cnt;
            put_bit((op == 2'b10) ? 1'b1 : wd[k], s, o);
            rd[k] = s; oe_all &= o; oe_any |= o;
        end
        mdio_in = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // Issue one frame and check it against the bench model.
    task automatic run_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd);
        logic [15:0] rd; logic oe_all, oe_any; int wbl, w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        send_frame(32, 2'b01, op, phy, rg, wd, rd, oe_all, oe_any, wbl);
        if (op == 2'b10) begin
            check("R5/R6 read data", 32'(rd), (phy == 5'(PHY)) ? 32'(exp_mem[rg]) : 32'hFFFF);
            check("R5 oe during data", 32'(oe_all), 32'd1);
            check("R5/R6 read strobe count", 32'(rd_cnt - r0), (phy == 5'(PHY)) ? 32'd1 : 32'd0);
        end else begin
            check("R7/R8 write count", 32'(wr_cnt - w0),
                  (op == 2'b01 && phy == 5'(PHY)) ? 32'd1 : 32'd0);
            check("R7 no commit before last bit", 32'(wbl - w0), 32'd0);
            check("R8 oe stays low", 32'(oe_any), 32'd0);
            if (op == 2'b01 && phy == 5'(PHY)) exp_mem[rg] = wd;
        end
        check("R5 oe released after frame", 32'(mdio_oe), 32'd0);
    endtask

    initial begin
        logic [15:0] rd; logic oe_all, oe_any; int wbl, w0, e0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 32; i++) begin
            dev_mem[i] = init_word(i);
            exp_mem[i] = init_word(i);
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 oe", 32'(mdio_oe), 0);
        check("R1 out", 32'(mdio_out), 0);
        check("R1 strobes", 32'({reg_rd_en, reg_wr_en, start_err}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4/R7: directed write then read back (R4 register index routing)
        run_frame(2'b01, 5'(PHY), 5'd4, 16'hA5C3);
        check("R4 reg_addr", 32'(reg_addr), 32'd4);
        check("R7 wdata", 32'(dev_mem[4]), 32'hA5C3);
        run_frame(2'b10, 5'(PHY), 5'd4, 16'h0);
        // R6: read to a foreign PHY
        run_frame(2'b10, 5'd7, 5'd4, 16'h0);
        // R8: foreign write and non-standard opcodes
        run_frame(2'b01, 5'd9, 5'd2, 16'h1234);
        run_frame(2'b11, 5'(PHY), 5'd2, 16'h4321);
        run_frame(2'b00, 5'(PHY), 5'd2, 16'h7777);

        // R2: short preamble; no zero after edge 32, so nothing may decode
        w0 = wr_cnt;
        send_frame(8, 2'b01, 2'b01, 5'(PHY), 5'd3, 16'h12FF, rd, oe_all, oe_any, wbl);
        check("R2 short preamble no write", 32'(wr_cnt - w0), 0);
        check("R2 short preamble no drive", 32'(oe_any), 0);
        run_frame(2'b10, 5'(PHY), 5'd3, 16'h0);

        // R3: bad start pair flags error but frame still decodes
        e0 = serr_cnt;
        send_frame(32, 2'b00, 2'b10, 5'(PHY), 5'd5, 16'h0, rd, oe_all, oe_any, wbl);
        check("R3 start error pulse", 32'(serr_cnt - e0), 1);
        check("R3 read after bad start", 32'(rd), 32'(exp_mem[5]));
        e0 = serr_cnt;
        run_frame(2'b10, 5'(PHY), 5'd5, 16'h0);
        check("R3 no error on good start", 32'(serr_cnt - e0), 0);

        // Random mix of frames
        for (int i = 0; i < 40; i++) begin
            logic [1:0] op; logic [4:0] phy, rg; logic [15:0] wd;
            op  = 2'($urandom_range(0, 3));
            phy = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'(PHY);
            rg  = 5'($urandom_range(0, 31));
            wd  = 16'($urandom);
            if ($urandom_range(0, 1) == 1 && op != 2'b10) op = 2'b01;
            run_frame(op, phy, rg, wd);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule